// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is a 32-bit scatter-gather DMA engine for a storage-card host. Software places a table of 64-bit descriptors in memory and hands the engine the table's base address with a one-cycle start pulse. The engine reads each descriptor over a simple request/grant word bus. A transfer descriptor makes it move a run of consecutive words between memory and the card data path. A link descriptor redirects the walk to another table. A no-op descriptor is skipped. The walk ends after the descriptor whose end flag is set. The card side is a plain word sink and source. In the memory-read direction, each word returned by memory is handed to the card sink. In the memory-write direction, the card source supplies each word written to memory.

A descriptor occupies two consecutive 32-bit words. The lower word carries the byte count and the attribute flags. The upper word carries the data or link address. A byte count of zero stands for 65536 bytes, so a transfer that is larger than that is split over several descriptors. The total size of a transfer, block count times block size (512 bytes unless another size is set), is what software spreads across the table. The engine itself follows only the flags.

The controller is one state machine with four states. IDLE waits for start. HDR_FETCH reads the lower descriptor word. PTR_FETCH reads the upper word. MOVE streams the data words. The named transitions are:
- start: IDLE to HDR_FETCH.
- invalid: HDR_FETCH to IDLE, raising the error status.
- header-ok: HDR_FETCH to PTR_FETCH.
- transfer: PTR_FETCH to MOVE.
- link-jump and skip: PTR_FETCH to HDR_FETCH.
- next-desc: MOVE to HDR_FETCH.
- finish: PTR_FETCH or MOVE to IDLE, pulsing done.

Top module: `adma_desc_walker`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, err_o, mem_req_o, card_tx_valid_o and card_rx_pop_o are all 0.
- R2: A start_i pulse in IDLE latches base_addr_i and to_mem_i. In the next cycle the engine requests a read at the base address. Once that read is granted, it requests a read at base+4.
- R3: Descriptor word 0 holds the byte count in bits 31:16, the valid flag in bit 0, the end flag in bit 1 and the action code in bits 5:4. The action codes are 00 or 01 for no-op, 10 for transfer and 11 for link. Descriptor word 1 holds the address.
- R4: A transfer descriptor moves ceil(count/4) words. The first word is at its address with bits 1:0 cleared, and each following word is 4 bytes higher.
- R5: A byte count of 0 moves 65536 bytes, which is 16384 words.
- R6: With to_mem_i=0 every data access is a read, and card_tx_valid_o pulses with card_tx_data_o equal to mem_rdata_i in the cycle of its grant. With to_mem_i=1 every data access is a write of card_rx_data_i, and card_rx_pop_o pulses in the cycle of its grant.
- R7: When a descriptor has no end flag and is not a link, the next descriptor is fetched at the current descriptor address plus 8.
- R8: In the cycle after the last grant of the end descriptor, done_o is 1 for exactly one cycle and busy_o is 0.
- R9: When a fetched word 0 has valid=0, the walk stops without fetching word 1. From the next cycle err_o is 1, with no done_o, and it stays 1 until the next accepted start, which clears it.
- R10: A no-op descriptor moves no data. A link descriptor without an end flag continues the walk at its address field. A no-op or link descriptor with the end flag finishes the walk as in R8.
- R11: A request that is not granted stays asserted in the next cycle with the same address and direction.
- R12: A start_i pulse while busy_o is 1 is ignored, and the access stream and completion are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a table walk (taken only when idle) |
| base_addr_i | input | ADDR_W | Byte address of the first descriptor |
| to_mem_i | input | 1 | 1: card data written to memory; 0: memory data read to card |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk finishes |
| err_o | output | 1 | Invalid descriptor seen; held until next start |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle (read data valid) |
| mem_rdata_i | input | 32 | Read data, valid with the grant |
| card_tx_valid_o | output | 1 | Word delivered to the card sink |
| card_tx_data_o | output | 32 | Word for the card sink |
| card_rx_data_i | input | 32 | Current word from the card source |
| card_rx_pop_o | output | 1 | Card source word consumed |

## Verification
The first request is due one cycle after the start pulse. Each later request appears one cycle after the previous grant. The card strobes are combinational with a grant, so they fall in the grant cycle itself, and done_o or err_o rises one cycle after the final grant. The bench drives grants and read data just after the falling edge, lets the combinational outputs settle, and then compares each granted access with the head of a queue that a behavioural walk of the same memory image has filled. The completion flags are sampled at the following falling edge and again one cycle later, which confirms that done_o is a single pulse and that err_o holds.

// File: rtl/adma_walk_pkg.sv
package adma_walk_pkg;

    // Fixed descriptor geometry
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 16;
    localparam int WORDS_W     = LEN_W - 1;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int DESC_BYTES  = 2 * WORD_BYTES;

    // Bit positions inside descriptor word 0
    localparam int HDR_VALID_BIT = 0;
    localparam int HDR_END_BIT   = 1;
    localparam int HDR_ACT_LSB   = 4;
    localparam int HDR_LEN_LSB   = 16;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_HDR,
        WALK_PTR,
        WALK_MOVE
    } walk_state_t;

    typedef enum logic [1:0] {
        ACT_NOP  = 2'b00,
        ACT_RSV  = 2'b01,
        ACT_TRAN = 2'b10,
        ACT_LINK = 2'b11
    } desc_act_t;

    typedef struct packed {
        logic                valid;
        logic                last;
        desc_act_t           act;
        logic [WORDS_W-1:0]  words;
    } desc_hdr_t;

endpackage

// File: rtl/adma_hdr_decode.sv
module adma_hdr_decode
    import adma_walk_pkg::*;
(
    input  logic [LEN_W-1:0] len_i,
    input  logic [1:0]       act_i,
    input  logic             valid_i,
    input  logic             end_i,
    output desc_hdr_t        hdr_o
);

    localparam int SUM_W = LEN_W + 1;
    localparam logic [WORDS_W-1:0] FULL_WORDS = WORDS_W'(1) << (LEN_W - 2);

    logic [SUM_W-1:0] rounded;

    always_comb begin
        rounded     = {1'b0, len_i} + SUM_W'(WORD_BYTES - 1);
        hdr_o.valid = valid_i;
        hdr_o.last  = end_i;
        hdr_o.act   = desc_act_t'(act_i);
        if (len_i == '0) begin
            hdr_o.words = FULL_WORDS;
        end else begin
            hdr_o.words = rounded[SUM_W-1:2];
        end
    end

endmodule

// File: rtl/adma_beat_ctr.sv
module adma_beat_ctr
    import adma_walk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [ADDR_W-1:0]  load_addr_i,
    input  logic [WORDS_W-1:0] load_words_i,
    input  logic               step_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               last_o
);

    logic [ADDR_W-1:0]  addr_q;
    logic [WORDS_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            addr_q <= {load_addr_i[ADDR_W-1:2], 2'b00};
            left_q <= load_words_i;
        end else if (step_i) begin
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            left_q <= left_q - WORDS_W'(1);
        end
    end

    assign addr_o = addr_q;
    assign last_o = (left_q == WORDS_W'(1));

endmodule

// File: rtl/adma_desc_walker.sv
module adma_desc_walker
    import adma_walk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic              to_mem_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              card_tx_valid_o,
    output logic [WORD_W-1:0] card_tx_data_o,
    input  logic [WORD_W-1:0] card_rx_data_i,
    output logic              card_rx_pop_o
);

    localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(WORD_BYTES);

    walk_state_t       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    desc_hdr_t         hdr_q, hdr_dec;
    logic              dir_q;
    logic              done_q, err_q;
    logic              fin, fail;
    logic              ctr_load, ctr_step, ctr_last;
    logic [ADDR_W-1:0] ctr_addr;
    logic [ADDR_W-1:0] rdata_addr;

    assign rdata_addr = mem_rdata_i[ADDR_W-1:0];

    adma_hdr_decode u_dec (
        .len_i   (mem_rdata_i[HDR_LEN_LSB +: LEN_W]),
        .act_i   (mem_rdata_i[HDR_ACT_LSB +: 2]),
        .valid_i (mem_rdata_i[HDR_VALID_BIT]),
        .end_i   (mem_rdata_i[HDR_END_BIT]),
        .hdr_o   (hdr_dec)
    );

    assign ctr_load = (state_q == WALK_PTR) && mem_gnt_i && (hdr_q.act == ACT_TRAN);
    assign ctr_step = (state_q == WALK_MOVE) && mem_gnt_i;

    adma_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (ctr_load),
        .load_addr_i  (rdata_addr),
        .load_words_i (hdr_q.words),
        .step_i       (ctr_step),
        .addr_o       (ctr_addr),
        .last_o       (ctr_last)
    );

    // Next-state and walk decisions
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        fin     = 1'b0;
        fail    = 1'b0;
        unique case (state_q)
            WALK_IDLE: begin
                if (start_i) begin
                    state_d = WALK_HDR;
                    ptr_d   = base_addr_i;
                end
            end
            WALK_HDR: begin
                if (mem_gnt_i) begin
                    if (!hdr_dec.valid) begin
                        fail    = 1'b1;
                        state_d = WALK_IDLE;
                    end else begin
                        state_d = WALK_PTR;
                    end
                end
            end
            WALK_PTR: begin
                if (mem_gnt_i) begin
                    if (hdr_q.act == ACT_TRAN) begin
                        state_d = WALK_MOVE;
                    end else if (hdr_q.last) begin
                        fin     = 1'b1;
                        state_d = WALK_IDLE;
                    end else if (hdr_q.act == ACT_LINK) begin
                        ptr_d   = rdata_addr;
                        state_d = WALK_HDR;
                    end else begin
                        ptr_d   = ptr_q + DESC_STEP;
                        state_d = WALK_HDR;
                    end
                end
            end
            WALK_MOVE: begin
                if (mem_gnt_i && ctr_last) begin
                    if (hdr_q.last) begin
                        fin     = 1'b1;
                        state_d = WALK_IDLE;
                    end else begin
                        ptr_d   = ptr_q + DESC_STEP;
                        state_d = WALK_HDR;
                    end
                end
            end
            default: state_d = WALK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            ptr_q   <= '0;
            hdr_q   <= '0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            done_q  <= fin;
            if (state_q == WALK_HDR && mem_gnt_i) begin
                hdr_q <= hdr_dec;
            end
            if (state_q == WALK_IDLE && start_i) begin
                dir_q <= to_mem_i;
                err_q <= 1'b0;
            end else if (fail) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o          = (state_q != WALK_IDLE);
        done_o          = done_q;
        err_o           = err_q;
        mem_req_o       = 1'b0;
        mem_we_o        = 1'b0;
        mem_addr_o      = '0;
        mem_wdata_o     = card_rx_data_i;
        card_tx_data_o  = mem_rdata_i;
        card_tx_valid_o = 1'b0;
        card_rx_pop_o   = 1'b0;
        unique case (state_q)
            WALK_IDLE: ;
            WALK_HDR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_q;
            end
            WALK_PTR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_q + HALF_STEP;
            end
            WALK_MOVE: begin
                mem_req_o       = 1'b1;
                mem_we_o        = dir_q;
                mem_addr_o      = ctr_addr;
                card_tx_valid_o = mem_gnt_i && !dir_q;
                card_rx_pop_o   = mem_gnt_i && dir_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/adma_walk_chk.sv
module adma_walk_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_gnt_i,
    input logic              card_tx_valid_o,
    input logic              card_rx_pop_o
);

    assert_first_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && mem_req_o && !mem_we_o);

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);

    assert_tx_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid_o |-> mem_req_o && mem_gnt_i && !mem_we_o);

    assert_pop_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_pop_o |-> mem_req_o && mem_gnt_i && mem_we_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !start_i |=> err_o);

    assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

endmodule

bind adma_desc_walker adma_walk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .err_o           (err_o),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_gnt_i       (mem_gnt_i),
    .card_tx_valid_o (card_tx_valid_o),
    .card_rx_pop_o   (card_rx_pop_o)
);

// File: tb/sim_adma_desc_walker.sv
module sim_adma_desc_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] base_addr_i;
    logic        to_mem_i;
    logic        busy_o, done_o, err_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_gnt_i;
    logic [31:0] mem_rdata_i;
    logic        card_tx_valid_o;
    logic [31:0] card_tx_data_o;
    logic [31:0] card_rx_data_i;
    logic        card_rx_pop_o;

    always #10 clk = ~clk;

    adma_desc_walker #(.ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .to_mem_i(to_mem_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rdata_i(mem_rdata_i),
        .card_tx_valid_o(card_tx_valid_o), .card_tx_data_o(card_tx_data_o),
        .card_rx_data_i(card_rx_data_i), .card_rx_pop_o(card_rx_pop_o)
    );

    typedef struct {
        bit        we;
        bit [31:0] addr;
        bit [31:0] data;
        string     tag;
    } acc_t;

    bit [31:0] mem [bit [31:0]];
    acc_t      exp_q[$];
    int        checks = 0;
    int        errors = 0;
    int        rx_cnt = 100;
    bit [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] rd(input bit [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // word 0: count[31:16], action[5:4], end[1], valid[0]
    function automatic bit [31:0] hdr(input int len, input bit [1:0] act,
                                      input bit e, input bit v);
        bit [31:0] w;
        w = '0;
        w[31:16] = len[15:0];
        w[5:4]   = act;
        w[1]     = e;
        w[0]     = v;
        return w;
    endfunction

    // Behavioural walk of the table: fills the expected access queue
    task automatic build(input bit [31:0] base, input bit dir, output bit exp_err);
        bit [31:0] p, w0, a;
        int        n, rxv, len;
        acc_t      e;
        p = base;
        rxv = rx_cnt;
        exp_err = 0;
        exp_q.delete();
        for (int d = 0; d < 64; d++) begin
            w0 = rd(p);
            e.we = 0; e.addr = p; e.data = w0; e.tag = "R2 R3 R7 header";
            exp_q.push_back(e);
            if (!w0[0]) begin
                exp_err = 1;
                break;
            end
            a = rd(p + 4);
            e.we = 0; e.addr = p + 4; e.data = a; e.tag = "R3 address word";
            exp_q.push_back(e);
            if (w0[5:4] == 2'b10) begin
                len = int'(w0[31:16]);
                n = (len == 0) ? 16384 : (len + 3) / 4;
                for (int i = 0; i < n; i++) begin
                    e.we = dir;
                    e.addr = {a[31:2], 2'b00} + 32'(4 * i);
                    e.data = dir ? 32'(rxv) : rd(e.addr);
                    e.tag = "R4 R5 R6 data";
                    if (dir) rxv++;
                    exp_q.push_back(e);
                end
            end
            if (w0[1]) break;
            if (w0[5:4] == 2'b11) p = a;
            else p = p + 8;
        end
    endtask

    task automatic run_case(input string name, input bit [31:0] base, input bit dir,
                            input int mode, input bit stray);
        bit   exp_err, g;
        int   cyc;
        acc_t h;
        build(base, dir, exp_err);
        @(negedge clk);
        start_i = 1; base_addr_i = base; to_mem_i = dir;
        @(negedge clk);
        start_i = 0;
        chk(err_o == 0, "R9", {name, " err cleared by start"}, err_o, 0);
        chk(busy_o == 1 && mem_req_o == 1 && mem_addr_o == base, "R2",
            {name, " first fetch"}, mem_addr_o, base);
        cyc = 0;
        while (1) begin
            start_i = (stray && cyc == 4);
            if (start_i) begin
                base_addr_i = 32'h0000_0F00;
                to_mem_i = ~dir;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            g = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 == 2) : (lfsr[0] | lfsr[3]);
            g = g && mem_req_o;
            mem_gnt_i = g;
            mem_rdata_i = rd(mem_addr_o);
            #1;
            if (!mem_req_o) begin
                chk(0, "R11", {name, " request dropped early"}, 0, 1);
                break;
            end
            if (g) begin
                h = exp_q.pop_front();
                chk(mem_addr_o == h.addr && mem_we_o == h.we, "R4",
                    {name, " ", h.tag, " address"}, mem_addr_o, h.addr);
                if (!h.we) begin
                    chk(card_tx_valid_o == (h.tag == "R4 R5 R6 data") &&
                        (card_tx_valid_o == 0 || card_tx_data_o == h.data),
                        "R6", {name, " card sink"}, card_tx_data_o, h.data);
                end else begin
                    chk(card_rx_pop_o == 1 && mem_wdata_o == h.data, "R6",
                        {name, " card source"}, mem_wdata_o, h.data);
                    rx_cnt++;
                    card_rx_data_i = 32'(rx_cnt);
                end
                if (exp_q.size() == 0) break;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 40000) begin
                chk(0, "R8", {name, " watchdog expired"}, cyc, 0);
                break;
            end
        end
        @(negedge clk);
        start_i = 0;
        mem_gnt_i = 0;
        chk(done_o == !exp_err, "R8", {name, " done after last grant"}, done_o, !exp_err);
        chk(err_o == exp_err, "R9", {name, " error flag"}, err_o, exp_err);
        chk(busy_o == 0 && mem_req_o == 0, "R8", {name, " idle after finish"}, busy_o, 0);
        if (stray)
            chk(done_o == 1, "R12", {name, " stray start ignored"}, done_o, 1);
        @(negedge clk);
        chk(done_o == 0, "R8", {name, " done is one pulse"}, done_o, 0);
        chk(err_o == exp_err, "R9", {name, " error held"}, err_o, exp_err);
    endtask

    initial begin
        rst_n = 0; start_i = 0; base_addr_i = 0; to_mem_i = 0;
        mem_gnt_i = 0; mem_rdata_i = 0; card_rx_data_i = 32'(rx_cnt);
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !mem_req_o && !card_tx_valid_o && !card_rx_pop_o,
            "R1", "outputs in reset", busy_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !mem_req_o, "R1", "outputs after reset", busy_o, 0);

        // single transfer descriptor, read direction
        mem[32'h1000] = hdr(16, 2'b10, 1, 1);
        mem[32'h1004] = 32'h0000_8000;
        for (int i = 0; i < 4; i++) mem[32'h8000 + 4 * i] = 32'hA500_0000 + i;
        run_case("R4 single", 32'h1000, 0, 0, 0);

        // transfer, no-op, transfer with odd count, write direction, stray start
        mem[32'h1100] = hdr(10, 2'b10, 0, 1);
        mem[32'h1104] = 32'h0000_9002;
        mem[32'h1108] = hdr(40, 2'b00, 0, 1);
        mem[32'h110C] = 32'h0000_7777;
        mem[32'h1110] = hdr(8, 2'b10, 1, 1);
        mem[32'h1114] = 32'h0000_9100;
        run_case("R7 R10 R12 chain", 32'h1100, 1, 1, 1);

        // link jump to a second table
        mem[32'h2000] = hdr(4, 2'b10, 0, 1);
        mem[32'h2004] = 32'h0000_A000;
        mem[32'h2008] = hdr(0, 2'b11, 0, 1);
        mem[32'h200C] = 32'h0000_3000;
        mem[32'h3000] = hdr(12, 2'b10, 1, 1);
        mem[32'h3004] = 32'h0000_A100;
        for (int i = 0; i < 4; i++) mem[32'hA100 + 4 * i] = 32'h5A00_0010 + i;
        run_case("R10 link", 32'h2000, 0, 2, 0);

        // invalid second descriptor
        mem[32'h4000] = hdr(8, 2'b10, 0, 1);
        mem[32'h4004] = 32'h0000_B000;
        mem[32'h4008] = hdr(8, 2'b10, 1, 0);
        run_case("R9 invalid", 32'h4000, 0, 2, 0);

        // end flag on no-op and on link descriptors
        mem[32'h5000] = hdr(64, 2'b01, 1, 1);
        mem[32'h5004] = 32'h0000_C000;
        run_case("R10 nop end", 32'h5000, 0, 1, 0);
        mem[32'h5100] = hdr(0, 2'b11, 1, 1);
        mem[32'h5104] = 32'h0000_5000;
        run_case("R10 link end", 32'h5100, 1, 0, 0);

        // zero count: 65536 bytes
        mem[32'h6000] = hdr(0, 2'b10, 1, 1);
        mem[32'h6004] = 32'h0002_0000;
        run_case("R5 zero count", 32'h6000, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule